// File: doc/BRIEF.md
# PLL Divider and Fraction Calculator

This block turns a requested clock frequency, given in kHz, into the settings a fractional-N PLL needs. A start pulse captures the request, together with a legal VCO window and a limit on the post-divider. The block first searches for the smallest power-of-two post-divider that moves the VCO frequency into the half-open window [low, high). It does this by doubling the frequency and the divider once per cycle.

Once the divider is found, the block splits it into two cascaded output-divider stages, each carried as a 2-bit code. It also works out the feedback multiplier against a 24 MHz reference: an integer part, and a 17-bit fraction of one reference step. Both divisions share one serial restoring divider. A successful run ends with a one-cycle `done` and updates all result outputs together. A rejected request ends with a one-cycle `err` and leaves every result output at its previous value.

The window is an input, so the same block serves a 1.6–3.2 GHz VCO and a 3–6 GHz VCO.

Top module: `pllcalc_top`

## Requirements
- R1: After reset, `done` and `err` are low and every result output (`vco_khz`, `post_div`, `od1_code`, `od2_code`, `mult_int`, `frac_word`, `frac_en`) is zero.
- R2: On success, `post_div` is the smallest power of two D, with D not above `div_limit`, for which `req_khz`×D lies in [`win_lo_khz`, `win_hi_khz`), and `vco_khz` equals `req_khz`×D. The low bound is inclusive and the high bound is exclusive.
- R3: If doubling the divider once more would take it above `div_limit` before the VCO has entered the window, the run ends with `err`, and `done` is not raised.
- R4: A request with `req_khz` strictly above `win_hi_khz` is rejected with `err` straight away, without a search.
- R5: The two stages are formed from the divider as follows. A divider of 8 or less gives stage one = divider and stage two = 1. A larger divider gives stage one = 8 and stage two = divider/8. Each stage value is encoded as 1→0, 2→1, 4→2, 8→3, and these codes are driven on `od1_code` (stage one) and `od2_code` (stage two).
- R6: `mult_int` equals `vco_khz` / 24000, truncated.
- R7: `frac_word` equals ((`vco_khz` mod 24000) × 2^17) / 24000, truncated. `frac_en` is high exactly when `frac_word` is nonzero.
- R8: After an `err`, all result outputs keep the values of the last successful run (zero if none).
- R9: A `start` that arrives while a run is in progress is ignored: it neither changes that run's result nor produces an extra result.
- R10: A `start` in the same cycle that `done` is high is accepted as a new request.
- R11: Every accepted request yields exactly one single-cycle pulse, either on `done` or on `err`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request strobe, taken only while idle |
| req_khz | input | 24 | Requested frequency in kHz |
| win_lo_khz | input | 24 | Inclusive lower VCO bound in kHz |
| win_hi_khz | input | 24 | Exclusive upper VCO bound in kHz |
| div_limit | input | 7 | Largest post-divider the search may use |
| done | output | 1 | One-cycle pulse: new settings are valid |
| err | output | 1 | One-cycle pulse: request rejected |
| vco_khz | output | 24 | Chosen VCO frequency in kHz |
| post_div | output | 7 | Chosen power-of-two post-divider |
| od1_code | output | 2 | Code of the first divider stage |
| od2_code | output | 2 | Code of the second divider stage |
| mult_int | output | 10 | Integer feedback multiplier |
| frac_word | output | 17 | Fractional feedback word |
| frac_en | output | 1 | Fraction in use |

## Verification
The end of one run and the acceptance of the next can fall in the same cycle. The `done` pulse of a finishing job is high while the controller is already idle, so a `start` in that cycle must be taken. The bench provokes this by raising `start` with a new request on the very cycle it first sees `done`. It then checks that both results come back in order, each matching the model. A companion case raises `start` during a search and again during a division. That case is judged by the first job's values being unchanged and by no stray result appearing in a following quiet window.

// File: rtl/pllcalc_pkg.sv
package pllcalc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_QUO    = 2'd2,
    ST_FRAC   = 2'd3
  } calc_st_e;

  // Map a power-of-two stage ratio onto its 2-bit selector.
  function automatic logic [1:0] stage_code(input logic [7:0] ratio);
    logic [1:0] c;
    case (ratio)
      8'd1:    c = 2'd0;
      8'd2:    c = 2'd1;
      8'd4:    c = 2'd2;
      8'd8:    c = 2'd3;
      default: c = 2'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pllcalc_restoring_div.sv
module pllcalc_restoring_div #(
  parameter int DVD_W = 32,
  parameter int DSR_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DSR_W-1:0] divisor,
  output logic             fin,
  output logic [DVD_W-1:0] quot,
  output logic [DSR_W-1:0] rem
);
  localparam int CNT_W = $clog2(DVD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DVD_W - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DVD_W-1:0] dvd_q, dvd_d;
  logic [DSR_W-1:0] rem_q, rem_d;
  logic [DSR_W-1:0] dsr_q, dsr_d;
  logic             fin_q, fin_d;

  logic [DSR_W:0] trial;
  logic [DSR_W:0] diff;
  logic           fits;

  always_comb begin
    trial = {rem_q, dvd_q[DVD_W-1]};
    diff  = trial - {1'b0, dsr_q};
    fits  = (trial >= {1'b0, dsr_q});
  end

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    dvd_d = dvd_q;
    rem_d = rem_q;
    dsr_d = dsr_q;
    fin_d = 1'b0;
    if (go) begin
      run_d = 1'b1;
      cnt_d = '0;
      dvd_d = dividend;
      rem_d = '0;
      dsr_d = divisor;
    end else if (run_q) begin
      rem_d = fits ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
      dvd_d = {dvd_q[DVD_W-2:0], fits};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      dvd_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      fin_q <= 1'b0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
      dvd_q <= dvd_d;
      rem_q <= rem_d;
      dsr_q <= dsr_d;
      fin_q <= fin_d;
    end
  end

  assign fin  = fin_q;
  assign quot = dvd_q;
  assign rem  = rem_q;

  // R6: the partial remainder never reaches the divisor once finished
  p_rem_below_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < dsr_q));

  // R11: a completion strobe never overlaps a running division
  p_fin_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> !run_q);

endmodule

// File: rtl/pllcalc_window_search.sv
module pllcalc_window_search #(
  parameter int FREQ_W = 24,
  parameter int DIV_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      go,
  input  logic [FREQ_W-1:0]         freq,
  input  logic [FREQ_W-1:0]         wlo,
  input  logic [FREQ_W-1:0]         whi,
  input  logic [DIV_W-1:0]          dlim,
  output logic                      hit,
  output logic                      miss,
  output logic [FREQ_W+DIV_W-1:0]   vco,
  output logic [DIV_W-1:0]          div
);
  localparam int VCO_W = FREQ_W + DIV_W;

  logic              active_q, active_d;
  logic [VCO_W-1:0]  vco_q, vco_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [FREQ_W-1:0] wlo_q, wlo_d;
  logic [FREQ_W-1:0] whi_q, whi_d;
  logic [DIV_W-1:0]  dlim_q, dlim_d;
  logic              hit_q, hit_d;
  logic              miss_q, miss_d;

  logic           in_win;
  logic [DIV_W:0] dbl;
  logic           over_lim;

  always_comb begin
    in_win   = (vco_q >= VCO_W'(wlo_q)) && (vco_q < VCO_W'(whi_q));
    dbl      = {div_q, 1'b0};
    over_lim = (dbl > {1'b0, dlim_q});
  end

  always_comb begin
    active_d = active_q;
    vco_d    = vco_q;
    div_d    = div_q;
    wlo_d    = wlo_q;
    whi_d    = whi_q;
    dlim_d   = dlim_q;
    hit_d    = 1'b0;
    miss_d   = 1'b0;
    if (go) begin
      active_d = 1'b1;
      vco_d    = VCO_W'(freq);
      div_d    = DIV_W'(1);
      wlo_d    = wlo;
      whi_d    = whi;
      dlim_d   = dlim;
    end else if (active_q) begin
      if (in_win) begin
        active_d = 1'b0;
        hit_d    = 1'b1;
      end else if (over_lim) begin
        active_d = 1'b0;
        miss_d   = 1'b1;
      end else begin
        vco_d = {vco_q[VCO_W-2:0], 1'b0};
        div_d = dbl[DIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      vco_q    <= '0;
      div_q    <= '0;
      wlo_q    <= '0;
      whi_q    <= '0;
      dlim_q   <= '0;
      hit_q    <= 1'b0;
      miss_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      vco_q    <= vco_d;
      div_q    <= div_d;
      wlo_q    <= wlo_d;
      whi_q    <= whi_d;
      dlim_q   <= dlim_d;
      hit_q    <= hit_d;
      miss_q   <= miss_d;
    end
  end

  assign hit  = hit_q;
  assign miss = miss_q;
  assign vco  = vco_q;
  assign div  = div_q;

  // R2: a found divider respects the captured limit
  p_div_within_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (div_q <= dlim_q) && (div_q != '0));

  // R9: the captured request stays frozen for the whole search
  p_request_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |=> $stable(wlo_q) && $stable(whi_q) && $stable(dlim_q));

endmodule

// File: rtl/pllcalc_od_split.sv
module pllcalc_od_split #(
  parameter int DIV_W = 7
) (
  input  logic [DIV_W-1:0] div,
  output logic [1:0]       code1,
  output logic [1:0]       code2
);
  import pllcalc_pkg::*;

  localparam logic [DIV_W-1:0] SPLIT = DIV_W'(8);

  logic [DIV_W-1:0] stage1;
  logic [DIV_W-1:0] stage2;

  always_comb begin
    if (div > SPLIT) begin
      stage1 = SPLIT;
      stage2 = div >> 3;
    end else begin
      stage1 = div;
      stage2 = DIV_W'(1);
    end
    code1 = stage_code(8'(stage1));
    code2 = stage_code(8'(stage2));
  end

endmodule

// File: rtl/pllcalc_top.sv
module pllcalc_top #(
  parameter int FREQ_W  = 24,
  parameter int DIV_W   = 7,
  parameter int REF_KHZ = 24000,
  parameter int FRAC_W  = 17
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [FREQ_W-1:0]             req_khz,
  input  logic [FREQ_W-1:0]             win_lo_khz,
  input  logic [FREQ_W-1:0]             win_hi_khz,
  input  logic [DIV_W-1:0]              div_limit,
  output logic                          done,
  output logic                          err,
  output logic [FREQ_W-1:0]             vco_khz,
  output logic [DIV_W-1:0]              post_div,
  output logic [1:0]                    od1_code,
  output logic [1:0]                    od2_code,
  output logic [FREQ_W-$clog2(REF_KHZ+1):0] mult_int,
  output logic [FRAC_W-1:0]             frac_word,
  output logic                          frac_en
);
  import pllcalc_pkg::*;

  localparam int REF_W = $clog2(REF_KHZ + 1);
  localparam int INT_W = FREQ_W - REF_W + 1;
  localparam int VCO_W = FREQ_W + DIV_W;
  localparam int NUM_W = REF_W + FRAC_W;
  localparam int DVD_W = (VCO_W > NUM_W) ? VCO_W : NUM_W;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic arst_n;
  assign arst_n = rst_sync_q;

  // submodule wiring
  logic             srch_go, srch_hit, srch_miss;
  logic [VCO_W-1:0] srch_vco;
  logic [DIV_W-1:0] srch_div;
  logic             dv_go, dv_fin;
  logic [DVD_W-1:0] dv_dvd, dv_quot;
  logic [REF_W-1:0] dv_rem;
  logic [1:0]       split_c1, split_c2;

  // controller state and staging
  calc_st_e          st_q, st_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              cap_srch, cap_int, commit;
  logic [FREQ_W-1:0] vco_s_q;
  logic [DIV_W-1:0]  div_s_q;
  logic [INT_W-1:0]  int_s_q;

  // committed results
  logic [FREQ_W-1:0] vco_o_q;
  logic [DIV_W-1:0]  div_o_q;
  logic [1:0]        od1_o_q, od2_o_q;
  logic [INT_W-1:0]  int_o_q;
  logic [FRAC_W-1:0] frac_o_q;
  logic              fen_o_q;

  pllcalc_window_search #(
    .FREQ_W (FREQ_W),
    .DIV_W  (DIV_W)
  ) u_search (
    .clk   (clk),
    .rst_n (arst_n),
    .go    (srch_go),
    .freq  (req_khz),
    .wlo   (win_lo_khz),
    .whi   (win_hi_khz),
    .dlim  (div_limit),
    .hit   (srch_hit),
    .miss  (srch_miss),
    .vco   (srch_vco),
    .div   (srch_div)
  );

  pllcalc_restoring_div #(
    .DVD_W (DVD_W),
    .DSR_W (REF_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (arst_n),
    .go       (dv_go),
    .dividend (dv_dvd),
    .divisor  (REF_W'(REF_KHZ)),
    .fin      (dv_fin),
    .quot     (dv_quot),
    .rem      (dv_rem)
  );

  pllcalc_od_split #(
    .DIV_W (DIV_W)
  ) u_split (
    .div   (div_s_q),
    .code1 (split_c1),
    .code2 (split_c2)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    done_d   = 1'b0;
    err_d    = 1'b0;
    srch_go  = 1'b0;
    dv_go    = 1'b0;
    dv_dvd   = '0;
    cap_srch = 1'b0;
    cap_int  = 1'b0;
    commit   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (req_khz > win_hi_khz) begin
            err_d = 1'b1;
          end else begin
            srch_go = 1'b1;
            st_d    = ST_SEARCH;
          end
        end
      end
      ST_SEARCH: begin
        if (srch_hit) begin
          cap_srch = 1'b1;
          dv_go    = 1'b1;
          dv_dvd   = DVD_W'(srch_vco);
          st_d     = ST_QUO;
        end else if (srch_miss) begin
          err_d = 1'b1;
          st_d  = ST_IDLE;
        end
      end
      ST_QUO: begin
        if (dv_fin) begin
          cap_int = 1'b1;
          dv_go   = 1'b1;
          dv_dvd  = DVD_W'({dv_rem, {FRAC_W{1'b0}}});
          st_d    = ST_FRAC;
        end
      end
      ST_FRAC: begin
        if (dv_fin) begin
          commit = 1'b1;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state and pulses
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // staging registers, each with its own enable
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      vco_s_q <= '0;
      div_s_q <= '0;
      int_s_q <= '0;
    end else begin
      if (cap_srch) begin
        vco_s_q <= srch_vco[FREQ_W-1:0];
        div_s_q <= srch_div;
      end
      if (cap_int) begin
        int_s_q <= dv_quot[INT_W-1:0];
      end
    end
  end

  // committed outputs: touched only by a successful run
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      vco_o_q  <= '0;
      div_o_q  <= '0;
      od1_o_q  <= '0;
      od2_o_q  <= '0;
      int_o_q  <= '0;
      frac_o_q <= '0;
      fen_o_q  <= 1'b0;
    end else if (commit) begin
      vco_o_q  <= vco_s_q;
      div_o_q  <= div_s_q;
      od1_o_q  <= split_c1;
      od2_o_q  <= split_c2;
      int_o_q  <= int_s_q;
      frac_o_q <= dv_quot[FRAC_W-1:0];
      fen_o_q  <= |dv_quot;
    end
  end

  assign done      = done_q;
  assign err       = err_q;
  assign vco_khz   = vco_o_q;
  assign post_div  = div_o_q;
  assign od1_code  = od1_o_q;
  assign od2_code  = od2_o_q;
  assign mult_int  = int_o_q;
  assign frac_word = frac_o_q;
  assign frac_en   = fen_o_q;

  // R11: success and rejection never coincide
  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({done_q, err_q}));

  // R11: a done strobe lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |=> !done_q);

  // R5: the two stage codes multiply back to the chosen divider
  p_codes_match_div_r5: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> (div_o_q == (DIV_W'(1) << (3'(od1_o_q) + 3'(od2_o_q)))));

  // R7: fraction flag agrees with the fraction word
  p_frac_flag_r7: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> (fen_o_q == (frac_o_q != '0)));

  // R8: a rejection leaves the committed results alone
  p_hold_on_err_r8: assert property (@(posedge clk) disable iff (!arst_n)
    err_q |-> $stable(vco_o_q) && $stable(div_o_q) && $stable(frac_o_q));

endmodule

// File: tb/pllcalc_top_bench.sv
`timescale 1ns/1ps
module pllcalc_top_bench;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [23:0] req_khz, win_lo_khz, win_hi_khz;
  logic [6:0]  div_limit;
  logic        done, err;
  logic [23:0] vco_khz;
  logic [6:0]  post_div;
  logic [1:0]  od1_code, od2_code;
  logic [9:0]  mult_int;
  logic [16:0] frac_word;
  logic        frac_en;

  pllcalc_top u_pllcalc_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_khz    (req_khz),
    .win_lo_khz (win_lo_khz),
    .win_hi_khz (win_hi_khz),
    .div_limit  (div_limit),
    .done       (done),
    .err        (err),
    .vco_khz    (vco_khz),
    .post_div   (post_div),
    .od1_code   (od1_code),
    .od2_code   (od2_code),
    .mult_int   (mult_int),
    .frac_word  (frac_word),
    .frac_en    (frac_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    bit          is_err;
    logic [23:0] vco;
    logic [6:0]  dv;
    logic [1:0]  o1;
    logic [1:0]  o2;
    logic [9:0]  mi;
    logic [16:0] fr;
    logic        fe;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last_ok;
  int   n_chk = 0;
  int   n_err = 0;
  bit   finished = 0;

  localparam longint LO_A = 1600000, HI_A = 3200000;
  localparam longint LO_B = 3000000, HI_B = 6000000;

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] lg2(longint x);
    case (x)
      1: return 2'd0;
      2: return 2'd1;
      4: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic exp_t model(longint f, longint lo, longint hi, longint md, string tag);
    exp_t e;
    longint v, d, s1, s2, fr;
    bit hit;
    e = last_ok;
    e.is_err = 1;
    if (f > hi) begin
      e.tag = "R4";
      return e;
    end
    v = f; d = 1; hit = 0;
    for (int i = 0; i < 16; i++) begin
      if (v >= lo && v < hi) begin hit = 1; break; end
      if (d * 2 > md) break;
      d = d * 2;
      v = v * 2;
    end
    if (!hit) begin
      e.tag = "R3";
      return e;
    end
    e.is_err = 0;
    e.tag = tag;
    e.vco = 24'(v);
    e.dv  = 7'(d);
    s1 = (d > 8) ? 8 : d;
    s2 = (d > 8) ? d / 8 : 1;
    e.o1 = lg2(s1);
    e.o2 = lg2(s2);
    e.mi = 10'(v / 24000);
    fr = ((v % 24000) * 131072) / 24000;
    e.fr = 17'(fr);
    e.fe = (fr != 0);
    return e;
  endfunction

  task automatic push(longint f, longint lo, longint hi, longint md, string tag);
    exp_t e;
    e = model(f, lo, hi, md, tag);
    sb.push_back(e);
    if (!e.is_err) last_ok = e;
  endtask

  task automatic set_req(longint f, longint lo, longint hi, longint md);
    req_khz    = 24'(f);
    win_lo_khz = 24'(lo);
    win_hi_khz = 24'(hi);
    div_limit  = 7'(md);
  endtask

  task automatic pulse(longint f, longint lo, longint hi, longint md);
    set_req(f, lo, hi, md);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_result();
    while (!(done || err)) @(negedge clk);
    @(negedge clk);
    chk("R11", done | err, 0);
  endtask

  task automatic job(longint f, longint lo, longint hi, longint md, string tag);
    push(f, lo, hi, md, tag);
    pulse(f, lo, hi, md);
    wait_result();
  endtask

  // monitor: pops the scoreboard whenever the block reports
  always @(negedge clk) begin
    if (rst_n && (done || err)) begin
      if (sb.size() == 0) begin
        chk("R9", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, done, !e.is_err);
        chk("R11", err, e.is_err);
        if (e.is_err) begin
          chk("R8", vco_khz, e.vco);
          chk("R8", post_div, e.dv);
          chk("R8", mult_int, e.mi);
          chk("R8", frac_word, e.fr);
        end else begin
          chk("R2", vco_khz, e.vco);
          chk("R2", post_div, e.dv);
          chk("R5", od1_code, e.o1);
          chk("R5", od2_code, e.o2);
          chk("R6", mult_int, e.mi);
          chk("R7", frac_word, e.fr);
          chk("R7", frac_en, e.fe);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL R11 watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    last_ok = '{is_err: 0, vco: '0, dv: '0, o1: '0, o2: '0, mi: '0, fr: '0, fe: 1'b0, tag: "R1"};
    rst_n = 1'b0;
    start = 1'b0;
    set_req(0, LO_A, HI_A, 64);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", done, 0);
    chk("R1", err, 0);
    chk("R1", vco_khz, 0);
    chk("R1", post_div, 0);
    chk("R1", {od1_code, od2_code}, 0);
    chk("R1", mult_int, 0);
    chk("R1", {frac_word, frac_en}, 0);

    // R8: error before any success keeps zeros
    job(25000, LO_A, HI_A, 32, "R3");
    // R2/R5: divider 16 splits 8 x 2
    job(148500, LO_A, HI_A, 64, "R2");
    // R5: divider 64, second stage 8
    job(25175, LO_A, HI_A, 64, "R5");
    // R5: divider 4, single stage
    job(594000, LO_A, HI_A, 64, "R5");
    // R2: lower bound inclusive, divider 1
    job(1600000, LO_A, HI_A, 64, "R2");
    // R3: upper bound exclusive, search runs out
    job(3200000, LO_A, HI_A, 64, "R3");
    // R4: above the window before searching
    job(3200001, LO_A, HI_A, 64, "R4");
    // R7: nonzero fraction in the high window
    job(5940000, LO_B, HI_B, 64, "R7");
    // R2: high window with divider 16
    job(371250, LO_B, HI_B, 64, "R2");
    // R6/R7: arbitrary fractional request
    job(2000001, LO_A, HI_A, 64, "R6");
    // R3: zero never enters the window
    job(0, LO_A, HI_A, 64, "R3");
    // R3: limit of 8 too small for 100 MHz
    job(100000, LO_A, HI_A, 8, "R3");
    // R8: outputs still hold after the errors
    job(2376000, LO_A, HI_A, 1, "R2");
    job(4000001, LO_A, HI_A, 64, "R4");

    // R9: starts during search and during division are ignored
    push(270000, LO_B, HI_B, 64, "R9");
    pulse(270000, LO_B, HI_B, 64);
    @(negedge clk);
    pulse(222222, LO_A, HI_A, 64);
    repeat (20) @(negedge clk);
    pulse(3200001, LO_A, HI_A, 64);
    wait_result();
    repeat (40) @(negedge clk);

    // R10: a start in the done cycle is taken
    push(148500, LO_A, HI_A, 64, "R2");
    pulse(148500, LO_A, HI_A, 64);
    while (!done) @(negedge clk);
    push(2000001, LO_A, HI_A, 64, "R10");
    pulse(2000001, LO_A, HI_A, 64);
    wait_result();
    repeat (40) @(negedge clk);
    chk("R10", sb.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule